// File: doc/BRIEF.md
# JTAG Debug Mailbox

This block lets an external JTAG host and an on-chip CPU pass 32-bit words to each other through one shared mailbox register. It sits behind a standard TAP state machine driven by TCK, TMS, TDI and a test reset. The host selects one of three scan paths through a 4-bit instruction register: a one-bit bypass path, a status path and the mailbox data path. Loading a dedicated instruction code raises an interrupt request to the CPU. The request stays asserted as a level until the CPU clears it.

Ownership of the mailbox is handed back and forth by a single ready flag. The host sees the flag by scanning the status path on TDO. The CPU sees it by reading its status register. While the flag is 1, the host owns the mailbox: its next data scan commits a new word and clears the flag. While the flag is 0, the CPU owns the mailbox: it may read the word, write a reply, and then set the flag to hand the mailbox back.

The flag and the mailbox live in the TCK domain. CPU writes are bundled and carried across to TCK with a toggle request/acknowledge handshake. Every change to the flag or the mailbox is signalled back with a toggle event. The CPU side then copies the stable values into shadow registers, so neither side ever sees a half-written word.

Top module: `jtag_mailbox`

## Requirements
- R1: Whatever the TAP state, five consecutive TCK rising edges with TMS=1 bring the TAP to Test-Logic-Reset, and the state sequencing follows IEEE 1149.1 for both the DR and the IR scan branches.
- R2: A test reset, or being in Test-Logic-Reset, loads the bypass code 4'hF into the instruction register. With bypass selected, the data path is one bit long: it captures 0, and TDO repeats TDI one TCK later.
- R3: An instruction scan shifts out the captured pattern 4'b0001, least significant bit first. The 4 bits shifted in take effect on Update-IR.
- R4: Updating the instruction register with code 4'h8 raises cpu_irq a few system clocks later. cpu_irq stays at 1 until the CPU writes the status address with bit 1 set. A status write with bit 1 at 0 leaves it set.
- R5: Instruction 4'h2 selects a 32-bit status path. Its Capture-DR puts the ready flag in bit 0, which is the first bit out on TDO. A CPU read of address 0 returns the flag in bit 1'b0 position (bit 0) and the interrupt level in bit 1, with all other bits 0.
- R6: Instruction 4'h3 selects the 32-bit data path. Capture-DR loads the mailbox, which shifts out least significant bit first. When the flag is 1, Update-DR commits the shifted word and clears the flag. The CPU then reads the new word at address 1.
- R7: An Update-DR on the data path while the flag is 0 leaves the mailbox unchanged.
- R8: A CPU write of address 0 with bit 0 set sets the flag, which then shows on a status scan and in the status read. A write with bit 0 at 0 does not clear the flag.
- R9: A CPU write of address 1 while the flag is 0 replaces the mailbox, and the host's next data scan shifts that word out. While the flag is 1, such a write is ignored.
- R10: CPU reads are registered: cpu_rdata takes the addressed value at the first clk edge with cpu_sel=1 and cpu_wr=0. Addresses other than 0 and 1 read as 0.
- R11: After reset, the flag, the interrupt, the mailbox and cpu_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of the CPU side |
| rst | input | 1 | Synchronous active-high reset, CPU side |
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset, TCK domain |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out; bit 0 of the active shift register in the Shift states, 0 otherwise |
| cpu_sel | input | 1 | CPU register access strobe |
| cpu_wr | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W | Register address: 0 status, 1 mailbox |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Registered read data |
| cpu_irq | output | 1 | Interrupt request level |

## Verification
A wrong TAP state or instruction code shows on TDO within the same scan. The captured pattern or the bypass delay comes out wrong, or a status scan returns mailbox bits. A flag that is stuck or lost shows within about ten TCK cycles of the next hand-over. Either the status read and the status scan disagree with the expected owner, or a committed word fails to appear at CPU address 1. A dropped or duplicated crossing command shows as a reply word that never reaches the host, or a flag that never rises after the CPU sets it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] IR_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_STATUS  = 4'h2;
    localparam logic [IR_W-1:0] IR_DATA    = 4'h3;
    localparam logic [IR_W-1:0] IR_IRQ     = 4'h8;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    localparam int A_STATUS     = 0;
    localparam int A_DATA       = 1;
    localparam int STAT_RDY_BIT = 0;
    localparam int STAT_IRQ_BIT = 1;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_STATUS,
        DR_DATA
    } dr_sel_e;

    // Command bundle carried from the CPU side into the TCK domain
    typedef struct packed {
        logic set_rdy;
        logic wr_data;
    } cmd_flags_t;

    function automatic tap_state_e tap_next(input tap_state_e cur, input logic tms);
        tap_state_e nxt;
        case (cur)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   nxt = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
        return nxt;
    endfunction

    function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] code);
        dr_sel_e sel;
        case (code)
            IR_STATUS: sel = DR_STATUS;
            IR_DATA:   sel = DR_DATA;
            default:   sel = DR_BYPASS;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/mbox_sync2.sv
module mbox_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mbox_tap_fsm.sv
module mbox_tap_fsm
    import mbox_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (trst) state <= TS_RESET;
        else      state <= tap_next(state, tms);
    end
endmodule

// File: rtl/mbox_scan_regs.sv
module mbox_scan_regs
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              trst,
    input  logic              tdi,
    input  tap_state_e        state,
    input  logic              cmd_req_s,
    input  cmd_flags_t        cmd_flags,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              tdo,
    output logic [IR_W-1:0]   ir,
    output logic              rdy,
    output logic [DATA_W-1:0] mbox,
    output logic              irq_tgl,
    output logic              evt_tgl,
    output logic              ack_tgl
);
    logic [IR_W-1:0]   ir_sr;
    logic [DATA_W-1:0] dr_sr;
    dr_sel_e           sel;
    logic              host_commit;
    logic              cmd_apply;

    assign sel         = dr_decode(ir);
    assign host_commit = (state == TS_UPD_DR) && (sel == DR_DATA) && rdy;
    // A host commit takes the cycle; a pending command waits one TCK
    assign cmd_apply   = (cmd_req_s != ack_tgl) && !host_commit;

    always_ff @(posedge tck) begin
        if (trst) begin
            ir      <= IR_BYPASS;
            ir_sr   <= '0;
            dr_sr   <= '0;
            irq_tgl <= 1'b0;
        end else begin
            case (state)
                TS_RESET:    ir    <= IR_BYPASS;
                TS_CAP_IR:   ir_sr <= IR_CAPTURE;
                TS_SHIFT_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TS_UPD_IR: begin
                    ir <= ir_sr;
                    if (ir_sr == IR_IRQ) irq_tgl <= ~irq_tgl;
                end
                TS_CAP_DR: begin
                    case (sel)
                        DR_DATA: dr_sr <= mbox;
                        DR_STATUS: begin
                            dr_sr               <= '0;
                            dr_sr[STAT_RDY_BIT] <= rdy;
                        end
                        default: dr_sr <= '0;
                    endcase
                end
                TS_SHIFT_DR: begin
                    if (sel == DR_BYPASS) dr_sr <= {{(DATA_W-1){1'b0}}, tdi};
                    else                  dr_sr <= {tdi, dr_sr[DATA_W-1:1]};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (trst) begin
            rdy     <= 1'b0;
            mbox    <= '0;
            evt_tgl <= 1'b0;
            ack_tgl <= 1'b0;
        end else if (host_commit) begin
            mbox    <= dr_sr;
            rdy     <= 1'b0;
            evt_tgl <= ~evt_tgl;
        end else if (cmd_apply) begin
            if (cmd_flags.wr_data && !rdy) mbox <= cmd_data;
            if (cmd_flags.set_rdy)         rdy  <= 1'b1;
            evt_tgl <= ~evt_tgl;
            ack_tgl <= cmd_req_s;
        end
    end

    always_comb begin
        case (state)
            TS_SHIFT_IR: tdo = ir_sr[0];
            TS_SHIFT_DR: tdo = dr_sr[0];
            default:     tdo = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbox_cpu_port.sv
module mbox_cpu_port
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              irq_s,
    input  logic              evt_s,
    input  logic              ack_s,
    input  logic              rdy_tck,
    input  logic [DATA_W-1:0] mbox_tck,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_irq,
    output logic              cmd_req,
    output cmd_flags_t        cmd_flags,
    output logic [DATA_W-1:0] cmd_data
);
    logic              irq_prev, evt_prev;
    logic              rdy_shadow;
    logic [DATA_W-1:0] data_shadow;
    logic              pend_set, pend_wr;
    logic [DATA_W-1:0] pend_data;
    logic              wr_stat, wr_data, rd_any, busy;
    logic [DATA_W-1:0] stat_word;

    assign wr_stat = cpu_sel && cpu_wr && (cpu_addr == ADDR_W'(A_STATUS));
    assign wr_data = cpu_sel && cpu_wr && (cpu_addr == ADDR_W'(A_DATA));
    assign rd_any  = cpu_sel && !cpu_wr;
    assign busy    = (cmd_req != ack_s);

    always_comb begin
        stat_word               = '0;
        stat_word[STAT_RDY_BIT] = rdy_shadow;
        stat_word[STAT_IRQ_BIT] = cpu_irq;
    end

    // Interrupt level and shadow copies of the TCK-domain state
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_prev    <= 1'b0;
            evt_prev    <= 1'b0;
            cpu_irq     <= 1'b0;
            rdy_shadow  <= 1'b0;
            data_shadow <= '0;
        end else begin
            irq_prev <= irq_s;
            evt_prev <= evt_s;
            if (irq_s != irq_prev)                       cpu_irq <= 1'b1;
            else if (wr_stat && cpu_wdata[STAT_IRQ_BIT]) cpu_irq <= 1'b0;
            if (evt_s != evt_prev) begin
                rdy_shadow  <= rdy_tck;
                data_shadow <= mbox_tck;
            end
        end
    end

    // Pending writes are bundled and launched one command at a time
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_set  <= 1'b0;
            pend_wr   <= 1'b0;
            pend_data <= '0;
            cmd_req   <= 1'b0;
            cmd_flags <= '0;
            cmd_data  <= '0;
        end else begin
            if (!busy && (pend_set || pend_wr)) begin
                cmd_flags <= '{set_rdy: pend_set, wr_data: pend_wr};
                cmd_data  <= pend_data;
                cmd_req   <= ~cmd_req;
                pend_set  <= 1'b0;
                pend_wr   <= 1'b0;
            end
            if (wr_stat && cpu_wdata[STAT_RDY_BIT]) pend_set <= 1'b1;
            if (wr_data) begin
                pend_wr   <= 1'b1;
                pend_data <= cpu_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
        end else if (rd_any) begin
            if (cpu_addr == ADDR_W'(A_STATUS))    cpu_rdata <= stat_word;
            else if (cpu_addr == ADDR_W'(A_DATA)) cpu_rdata <= data_shadow;
            else                                  cpu_rdata <= '0;
        end
    end
endmodule

// File: rtl/jtag_mailbox.sv
module jtag_mailbox
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tck,
    input  logic              trst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_irq
);
    localparam int BACK_W = 3;

    tap_state_e        tap_state;
    logic [IR_W-1:0]   ir;
    logic              rdy_tck;
    logic [DATA_W-1:0] mbox_tck;
    logic              irq_tgl, evt_tgl, ack_tgl;
    logic              cmd_req, cmd_req_s;
    cmd_flags_t        cmd_flags;
    logic [DATA_W-1:0] cmd_data;
    logic              irq_s, evt_s, ack_s;

    mbox_tap_fsm u_fsm (
        .tck   (tck),
        .trst  (trst),
        .tms   (tms),
        .state (tap_state)
    );

    mbox_scan_regs #(.DATA_W(DATA_W)) u_regs (
        .tck       (tck),
        .trst      (trst),
        .tdi       (tdi),
        .state     (tap_state),
        .cmd_req_s (cmd_req_s),
        .cmd_flags (cmd_flags),
        .cmd_data  (cmd_data),
        .tdo       (tdo),
        .ir        (ir),
        .rdy       (rdy_tck),
        .mbox      (mbox_tck),
        .irq_tgl   (irq_tgl),
        .evt_tgl   (evt_tgl),
        .ack_tgl   (ack_tgl)
    );

    mbox_sync2 #(.W(1)) u_sync_req (
        .clk (tck),
        .rst (trst),
        .d   (cmd_req),
        .q   (cmd_req_s)
    );

    mbox_sync2 #(.W(BACK_W)) u_sync_back (
        .clk (clk),
        .rst (rst),
        .d   ({irq_tgl, evt_tgl, ack_tgl}),
        .q   ({irq_s, evt_s, ack_s})
    );

    mbox_cpu_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cpu (
        .clk       (clk),
        .rst       (rst),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .irq_s     (irq_s),
        .evt_s     (evt_s),
        .ack_s     (ack_s),
        .rdy_tck   (rdy_tck),
        .mbox_tck  (mbox_tck),
        .cpu_rdata (cpu_rdata),
        .cpu_irq   (cpu_irq),
        .cmd_req   (cmd_req),
        .cmd_flags (cmd_flags),
        .cmd_data  (cmd_data)
    );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tck,
    input logic              trst,
    input logic              tms,
    input tap_state_e        tap_state,
    input logic [IR_W-1:0]   ir,
    input logic              rdy,
    input logic [DATA_W-1:0] mbox,
    input logic              cmd_req,
    input logic              cmd_req_s,
    input logic              ack_tgl,
    input logic              ack_s,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wbit_irq,
    input logic              cpu_irq
);
    logic [2:0] ones_cnt;

    always_ff @(posedge tck) begin
        if (trst || !tms)          ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    // R1: five TMS=1 edges always land in Test-Logic-Reset
    a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (trst)
        (ones_cnt == 3'd5) |-> (tap_state == TS_RESET));

    // R2: Test-Logic-Reset forces the bypass code
    a_r2_reset_loads_bypass: assert property (@(posedge tck) disable iff (trst)
        (tap_state == TS_RESET) |=> (ir == IR_BYPASS));

    // R6: a host commit hands ownership to the CPU
    a_r6_commit_clears_flag: assert property (@(posedge tck) disable iff (trst)
        (tap_state == TS_UPD_DR && ir == IR_DATA && rdy) |=> !rdy);

    // R7: a locked Update-DR keeps the mailbox
    a_r7_locked_update_keeps: assert property (@(posedge tck) disable iff (trst)
        (tap_state == TS_UPD_DR && ir == IR_DATA && !rdy && cmd_req_s == ack_tgl)
        |=> $stable(mbox));

    // R8: the flag only rises through a CPU command
    a_r8_flag_rise_needs_cmd: assert property (@(posedge tck) disable iff (trst)
        $rose(rdy) |-> $past(cmd_req_s != ack_tgl));

    // R8: at most one command in flight across the handshake
    a_r8_one_cmd_in_flight: assert property (@(posedge clk) disable iff (rst)
        (cmd_req != ack_s) |=> $stable(cmd_req));

    // R4: the interrupt level only drops on a clearing status write
    a_r4_irq_held: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_irq) |-> $past(cpu_sel && cpu_wr && cpu_addr == ADDR_W'(A_STATUS) && cpu_wbit_irq));
endmodule

bind jtag_mailbox mbox_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tck          (tck),
    .trst         (trst),
    .tms          (tms),
    .tap_state    (tap_state),
    .ir           (ir),
    .rdy          (rdy_tck),
    .mbox         (mbox_tck),
    .cmd_req      (cmd_req),
    .cmd_req_s    (cmd_req_s),
    .ack_tgl      (ack_tgl),
    .ack_s        (ack_s),
    .cpu_sel      (cpu_sel),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wbit_irq (cpu_wdata[1]),
    .cpu_irq      (cpu_irq)
);

// File: tb/jtag_mailbox_bench.sv
module jtag_mailbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TCK_PERIOD = 4 * CLK_PERIOD;
    localparam logic [3:0] C_BYPASS = 4'hF;
    localparam logic [3:0] C_STATUS = 4'h2;
    localparam logic [3:0] C_DATA   = 4'h3;
    localparam logic [3:0] C_IRQ    = 4'h8;
    localparam int NVEC = 4;
    // {host word shifted in, CPU reply written before the scan}
    localparam logic [63:0] VECS [NVEC] = '{
        {32'h0000_0001, 32'hCAFE_0001},
        {32'hA5A5_5A5A, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h1357_9BDF},
        {32'h8000_0000, 32'hFFFF_FFFE}
    };

    logic clk = 1'b0, tck = 1'b0;
    logic rst, trst, tms, tdi;
    logic tdo;
    logic cpu_sel, cpu_wr, cpu_irq;
    logic [1:0]  cpu_addr;
    logic [31:0] cpu_wdata, cpu_rdata;
    int n_chk = 0, n_err = 0;
    logic [31:0] rd, sh;
    logic [3:0]  cap;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(TCK_PERIOD/2) tck = ~tck;

    jtag_mailbox u_jtag_mailbox (
        .clk(clk), .rst(rst), .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tap_step(input logic m, input logic d, output logic o);
        @(negedge tck);
        o   = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic tap_reset();
        logic o;
        for (int i = 0; i < 5; i++) tap_step(1'b1, 1'b0, o);
        tap_step(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] got);
        logic o;
        tap_step(1'b1, 1'b0, o); tap_step(1'b1, 1'b0, o);
        tap_step(1'b0, 1'b0, o); tap_step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            tap_step(i == 3, code[i], o);
            got[i] = o;
        end
        tap_step(1'b1, 1'b0, o); tap_step(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
        logic o;
        dout = '0;
        tap_step(1'b1, 1'b0, o); tap_step(1'b0, 1'b0, o); tap_step(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            tap_step(i == len - 1, din[i], o);
            dout[i] = o;
        end
        tap_step(1'b1, 1'b0, o); tap_step(1'b0, 1'b0, o);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        @(negedge clk);
        cpu_sel = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic settle();
        repeat (10) @(negedge tck);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [3:0] unused_cap;
        rst = 1'b1; trst = 1'b1; tms = 1'b1; tdi = 1'b0;
        cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge tck);
        rst = 1'b0; trst = 1'b0;
        @(negedge clk);

        // R11: reset state
        check("R11 rdata after reset", cpu_rdata, 32'h0);
        check("R11 irq after reset", {31'h0, cpu_irq}, 32'h0);
        cpu_read(2'd0, rd); check("R11 status after reset", rd, 32'h0);
        cpu_read(2'd1, rd); check("R11 mailbox after reset", rd, 32'h0);

        // R3: IR capture pattern
        tap_reset();
        scan_ir(C_STATUS, cap);
        check("R3 IR capture bits", {28'h0, cap}, 32'h1);
        // R5: status scan after reset shows flag 0 (IR now status)
        scan_dr(4, 32'h0000_000F, sh);
        check("R5 status scan flag 0", sh, 32'h0);

        // R2: Test-Logic-Reset loads bypass, 1-bit delay path
        tap_reset();
        scan_dr(4, 32'h0000_000B, sh);
        check("R2 bypass delay", sh, 32'h6);

        // R1: from Shift-DR with status selected, five TMS=1 edges reset the TAP
        scan_ir(C_STATUS, unused_cap);
        begin
            logic o;
            tap_step(1'b1, 1'b0, o); tap_step(1'b0, 1'b0, o); tap_step(1'b0, 1'b0, o);
            for (int i = 0; i < 5; i++) tap_step(1'b1, 1'b0, o);
            tap_step(1'b0, 1'b0, o);
        end
        scan_dr(4, 32'h0000_000B, sh);
        check("R1 five ones reach reset", sh, 32'h6);

        // Main hand-over loop: R9 reply, R8 set, R5 status, R6 commit
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] host, reply;
            host  = VECS[i][63:32];
            reply = VECS[i][31:0];
            cpu_write(2'd1, reply);
            cpu_write(2'd0, 32'h1);
            settle();
            cpu_read(2'd0, rd); check("R8 status read flag set", rd, 32'h1);
            scan_ir(C_STATUS, unused_cap);
            scan_dr(32, 32'h0, sh);
            check("R5 status scan flag bit0", sh, 32'h1);
            scan_ir(C_DATA, unused_cap);
            scan_dr(32, host, sh);
            check("R9 reply shifted out", sh, reply);
            settle();
            cpu_read(2'd0, rd); check("R6 flag cleared on commit", rd, 32'h0);
            cpu_read(2'd1, rd); check("R6 committed word", rd, host);
        end

        // R7: locked update (flag 0) leaves the mailbox
        scan_dr(32, 32'h1234_5678, sh);
        settle();
        cpu_read(2'd1, rd); check("R7 locked update ignored", rd, 32'h8000_0000);
        cpu_read(2'd0, rd); check("R7 flag still 0", rd, 32'h0);

        // R4 / R5: interrupt instruction and its clearing
        scan_ir(C_IRQ, unused_cap);
        settle();
        check("R4 irq raised", {31'h0, cpu_irq}, 32'h1);
        cpu_read(2'd0, rd); check("R5 status shows irq bit1", rd, 32'h2);
        cpu_write(2'd0, 32'h0);
        settle();
        check("R4 irq kept without bit1", {31'h0, cpu_irq}, 32'h1);
        cpu_write(2'd0, 32'h2);
        @(negedge clk);
        check("R4 irq cleared", {31'h0, cpu_irq}, 32'h0);
        cpu_read(2'd0, rd); check("R8 bit0=0 did not set flag", rd, 32'h0);

        // R8 / R9: write of 0 keeps flag, CPU data write while flag 1 ignored
        cpu_write(2'd0, 32'h1);
        settle();
        cpu_write(2'd0, 32'h0);
        cpu_write(2'd1, 32'hDEAD_BEEF);
        settle();
        cpu_read(2'd0, rd); check("R8 zero write keeps flag", rd, 32'h1);
        cpu_read(2'd1, rd); check("R9 CPU write ignored while flag 1", rd, 32'h8000_0000);
        scan_ir(C_DATA, unused_cap);
        scan_dr(32, 32'h0F0F_1234, sh);
        check("R9 host sees old mailbox", sh, 32'h8000_0000);
        settle();
        cpu_read(2'd1, rd); check("R6 second commit word", rd, 32'h0F0F_1234);

        // R10: unmapped address and registered read
        cpu_read(2'd2, rd); check("R10 unmapped reads 0", rd, 32'h0);
        cpu_read(2'd1, rd); check("R10 data read", rd, 32'h0F0F_1234);

        scan_ir(C_BYPASS, unused_cap);
        summary();
        $finish;
    end
endmodule